// File: doc/BRIEF.md
# Tachometer Period Discriminator with Lock Flag

This block judges the speed of a motor from its tachometer pulse. A digitized tach level arrives on `fg_in`, and a reference tick on `ref_tick` marks the time base. The block counts reference ticks between consecutive rising edges of the tach signal. The intended speed is one tach cycle per `TARGET` ticks, which defaults to 512. The measured count therefore stands in for the period, and the block compares it with the target to decide whether the motor runs fast or slow.

Three results come out of the block. The first is a direction decision, taken on every other tach interval: one interval is measured, and the interval after it is passed over while the result is presented. The second is a phase-error pulse produced on every interval. Its level shows the sign of the error and its length shows the size. The third is an active-low lock flag, asserted when the period lies within a tolerance band around the target; the default band is ±32 counts, or ±6.25 %.

The block runs only while `run` is high. When `run` is low, every counter is held cleared and the lock flag reads unlocked. If the tach stops so that the counter reaches its ceiling, the block reports the motor as slow and unlocked straight away. The next edge after that measures the ceiling value, and so it reads as slow as well.

Top module: `fg_speed_disc`

## Requirements
- R1: The measured count of an interval is the number of clock cycles with `ref_tick` high, counted from one detected rising edge of `fg_in` to the next. The first edge after `run` rises only starts timing.
- R2: At each speed evaluation, `spd_accel` becomes 1 if the count is greater than `TARGET` (motor slow) and 0 if the count is at or below `TARGET`. It holds that value until the next evaluation.
- R3: At each speed evaluation, `lock_n` becomes 0 if the count lies within `TARGET-LOCK_TOL` and `TARGET+LOCK_TOL` inclusive (480..544 with the defaults). Otherwise it becomes 1.
- R4: Speed evaluations take place on alternate measured intervals only. Each one raises `err_vld` for a single clock, so consecutive strobes lie two tach periods apart.
- R5: On every measured interval, `ph_lag` becomes 1 if the count exceeds `TARGET` and 0 otherwise. `ph_pulse` then stays high for |count − `TARGET`| cycles in which `ref_tick` is high. With an exact count it does not pulse.
- R6: The counter saturates at 2^`CNT_W`−1 (1023). The clock after it reaches that value with no edge, `spd_accel` is 1 and `lock_n` is 1.
- R7: While `run` is 0, from the next clock on: `lock_n` = 1, `err_vld` = 0, `ph_pulse` = 0, and no evaluation takes place.
- R8: Synchronous active-high `rst` sets `lock_n` = 1, `spd_accel` = 0, `err_vld` = 0, `ph_pulse` = 0 and `ph_lag` = 0.
- R9: Cycles with `ref_tick` low neither add to the count nor shorten a phase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 = operate, 0 = stopped and cleared |
| ref_tick | input | 1 | Reference time-base enable, one tick per high cycle |
| fg_in | input | 1 | Digitized tachometer level, asynchronous |
| spd_accel | output | 1 | 1 = accelerate (slow), 0 = decelerate |
| err_vld | output | 1 | One-clock strobe when a speed evaluation updates |
| ph_lag | output | 1 | Phase-error sign, 1 = period longer than target |
| ph_pulse | output | 1 | Phase-error pulse, length equals error magnitude in ticks |
| lock_n | output | 1 | 0 = speed inside the lock band |

## Verification
The assertions rely on rising edges of `fg_in` being at least two clocks apart after synchronization, which the edge detector guarantees. They also rely on a phase pulse being no longer than the interval that follows it. Because of that second assumption, the stimulus keeps every period between 400 and 1100 ticks, so that no error magnitude reaches the next edge. The stimulus changes the tach period and the tick pattern only while `run` is low, and it then waits several periods. As a result, every checked interval is measured at one constant period.

// File: rtl/fg_disc_pkg.sv
package fg_disc_pkg;
  typedef enum logic {
    HALF_COUNT = 1'b0,
    HALF_SKIP  = 1'b1
  } spd_half_e;
endpackage

// File: rtl/fg_edge_sync.sv
module fg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fg_raw,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], fg_raw};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/fg_period_cnt.sv
module fg_period_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas,
  output logic             sat_hit
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else if (rise) begin
      cnt    <= '0;
      primed <= 1'b1;
    end else if (tick && cnt != CEIL) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign meas_vld = run & primed & rise;
  assign meas     = (cnt == CEIL) ? CEIL : cnt + {{(CNT_W-1){1'b0}}, tick};
  assign sat_hit  = run & primed & ~rise & tick & (cnt == CEIL - 1'b1);

  // R1
  edge_restart_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> cnt == '0);
  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !rise && !tick) |=> (cnt == $past(cnt) || !run));
endmodule

// File: rtl/fg_speed_eval.sv
module fg_speed_eval
  import fg_disc_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int TARGET   = 512,
  parameter int LOCK_TOL = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] meas,
  input  logic             sat_hit,
  output logic             accel,
  output logic             lock_n,
  output logic             err_vld
);
  localparam logic [CNT_W-1:0] TGT = CNT_W'(TARGET);
  localparam logic [CNT_W-1:0] LO  = CNT_W'(TARGET - LOCK_TOL);
  localparam logic [CNT_W-1:0] HI  = CNT_W'(TARGET + LOCK_TOL);

  spd_half_e half;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half    <= HALF_COUNT;
      accel   <= 1'b0;
      lock_n  <= 1'b1;
      err_vld <= 1'b0;
    end else begin
      err_vld <= 1'b0;
      if (meas_vld) begin
        half <= (half == HALF_COUNT) ? HALF_SKIP : HALF_COUNT;
        if (half == HALF_COUNT) begin
          err_vld <= 1'b1;
          accel   <= meas > TGT;
          lock_n  <= !(meas >= LO && meas <= HI);
        end
      end else if (sat_hit) begin
        accel  <= 1'b1;
        lock_n <= 1'b1;
      end
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> !err_vld);
  // R4
  strobe_alt_chk: assert property (@(posedge clk) disable iff (rst)
    err_vld |-> half == HALF_SKIP);
  // R7
  stop_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> lock_n && !err_vld);
  // R6
  sat_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (sat_hit && run) |=> (lock_n && accel) || !run);
endmodule

// File: rtl/fg_phase_pulse.sv
module fg_phase_pulse #(
  parameter int CNT_W  = 10,
  parameter int TARGET = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             meas_vld,
  input  logic [CNT_W-1:0] meas,
  output logic             ph_lag,
  output logic             ph_pulse
);
  localparam logic [CNT_W-1:0] TGT = CNT_W'(TARGET);

  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] diff;

  assign diff = (meas > TGT) ? meas - TGT : TGT - meas;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      rem      <= '0;
      ph_pulse <= 1'b0;
      ph_lag   <= 1'b0;
    end else if (meas_vld) begin
      ph_lag   <= meas > TGT;
      rem      <= diff;
      ph_pulse <= diff != '0;
    end else if (tick && rem != '0) begin
      rem      <= rem - 1'b1;
      ph_pulse <= rem > 1;
    end
  end

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_pulse && !tick && !meas_vld && run) |=> ph_pulse || !run);
  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !ph_pulse);
endmodule

// File: rtl/fg_speed_disc.sv
module fg_speed_disc #(
  parameter int CNT_W       = 10,
  parameter int TARGET      = 512,
  parameter int LOCK_TOL    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_tick,
  input  logic fg_in,
  output logic spd_accel,
  output logic err_vld,
  output logic ph_lag,
  output logic ph_pulse,
  output logic lock_n
);
  logic             rise;
  logic             meas_vld;
  logic [CNT_W-1:0] meas;
  logic             sat_hit;

  fg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .fg_raw(fg_in), .rise(rise)
  );

  fg_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(ref_tick), .rise(rise),
    .meas_vld(meas_vld), .meas(meas), .sat_hit(sat_hit)
  );

  fg_speed_eval #(.CNT_W(CNT_W), .TARGET(TARGET), .LOCK_TOL(LOCK_TOL)) u_eval (
    .clk(clk), .rst(rst), .run(run), .meas_vld(meas_vld), .meas(meas),
    .sat_hit(sat_hit), .accel(spd_accel), .lock_n(lock_n), .err_vld(err_vld)
  );

  fg_phase_pulse #(.CNT_W(CNT_W), .TARGET(TARGET)) u_phase (
    .clk(clk), .rst(rst), .run(run), .tick(ref_tick), .meas_vld(meas_vld),
    .meas(meas), .ph_lag(ph_lag), .ph_pulse(ph_pulse)
  );
endmodule

// File: tb/fg_speed_disc_bench.sv
module fg_speed_disc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // period(clocks), accel, lock_n, lag, width
  localparam int VEC [NVEC][5] = '{
    '{512, 0, 0, 0, 0},  '{500, 0, 0, 0, 12}, '{530, 1, 0, 1, 18},
    '{480, 0, 0, 0, 32}, '{544, 1, 0, 1, 32}, '{479, 0, 1, 0, 33},
    '{545, 1, 1, 1, 33}, '{700, 1, 1, 1, 188}, '{400, 0, 1, 0, 112},
    '{513, 1, 0, 1, 1}
  };

  logic clk = 0, rst = 1, run = 0, ref_tick = 1, fg_in = 0;
  logic spd_accel, err_vld, ph_lag, ph_pulse, lock_n;
  int   fg_period = 512;
  bit   fg_hold = 0, tick_mode = 0;
  int   n_tests = 0, n_fail = 0;

  fg_speed_disc u_fg_speed_disc (
    .clk(clk), .rst(rst), .run(run), .ref_tick(ref_tick), .fg_in(fg_in),
    .spd_accel(spd_accel), .err_vld(err_vld), .ph_lag(ph_lag),
    .ph_pulse(ph_pulse), .lock_n(lock_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    ref_tick = tick_mode ? ~ref_tick : 1'b1;
  end

  initial forever begin
    if (fg_hold) begin
      fg_in = 0;
      @(negedge clk);
    end else begin
      fg_in = 1;
      repeat (fg_period / 2) @(negedge clk);
      fg_in = 0;
      repeat (fg_period - fg_period / 2) @(negedge clk);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_strobe(output int clks);
    clks = 0;
    do begin
      @(negedge clk);
      clks++;
    end while (!err_vld && clks < 6000);
    if (!err_vld) chk("R4 strobe timeout", 0, 1);
  endtask

  task automatic restart(input int period, input bit tmode);
    @(negedge clk);
    run = 0;
    fg_period = period;
    tick_mode = tmode;
    repeat (3 * period) @(negedge clk);
    run = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    int w, t, rises;
    bit prev, seen;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 lock_n", lock_n, 1);
    chk("R8 accel", spd_accel, 0);
    chk("R8 err_vld", err_vld, 0);
    chk("R8 ph_pulse", ph_pulse, 0);
    chk("R8 ph_lag", ph_lag, 0);
    rst = 0;

    // R1 R2 R3 R5 table
    for (int i = 0; i < NVEC; i++) begin
      restart(VEC[i][0], 0);
      wait_strobe(t);
      chk($sformatf("R2 accel P=%0d", VEC[i][0]), spd_accel, VEC[i][1]);
      chk($sformatf("R3 lock_n P=%0d", VEC[i][0]), lock_n, VEC[i][2]);
      chk($sformatf("R5 lag P=%0d", VEC[i][0]), ph_lag, VEC[i][3]);
      w = 0;
      while (ph_pulse && w < 2000) begin
        w++;
        @(negedge clk);
      end
      chk($sformatf("R5 width P=%0d", VEC[i][0]), w, VEC[i][4]);
    end

    // R4 alternation: strobes two periods apart, phase pulses every period
    restart(530, 0);
    wait_strobe(t);
    rises = 0;
    prev = 1;
    t = 0;
    do begin
      @(negedge clk);
      t++;
      if (ph_pulse && !prev) rises++;
      prev = ph_pulse;
    end while (!err_vld && t < 3000);
    chk("R4 strobe spacing", t, 1060);
    chk("R5 pulses per two periods", rises, 2);

    // R7 stop
    @(negedge clk);
    run = 0;
    @(negedge clk);
    chk("R7 lock_n on stop", lock_n, 1);
    seen = 0;
    repeat (2000) begin
      @(negedge clk);
      if (err_vld || ph_pulse) seen = 1;
    end
    chk("R7 quiet while stopped", seen, 0);
    run = 1;
    wait_strobe(t);
    chk("R1 first edge only primes", (t >= 530 && t <= 1070) ? 1 : 0, 1);

    // R9 tick gating: 1024 clocks with ticks every other clock = 512 ticks
    restart(1024, 1);
    wait_strobe(t);
    chk("R9 lock_n half-rate 512", lock_n, 0);
    chk("R9 accel half-rate 512", spd_accel, 0);
    restart(1100, 1);
    wait_strobe(t);
    chk("R9 lock_n half-rate 550", lock_n, 1);
    chk("R9 accel half-rate 550", spd_accel, 1);

    // R6 saturation
    restart(512, 0);
    wait_strobe(t);
    fg_hold = 1;
    chk("R6 locked before stall", lock_n, 0);
    repeat (900) @(negedge clk);
    chk("R6 still locked below ceiling", lock_n, 0);
    repeat (200) @(negedge clk);
    chk("R6 lock_n at ceiling", lock_n, 1);
    chk("R6 accel at ceiling", spd_accel, 1);
    fg_hold = 0;

    report();
  end
endmodule